// File: doc/BRIEF.md
# Sample and Clamp Pulse Conditioner

This block sits between an external timing generator and the sampling and clamping datapaths of an image-sensor front end. It receives four raw timing pulses: reference-level sample, data-level sample, dummy-pixel clamp and black-pixel clamp. It also receives the conversion clock and a pre-blanking indication. Each pulse arrives with an active level that the board chooses. A per-pulse polarity bit turns each one into an active-high strobe. The strobes are then combined into the qualified enables that the analog side consumes.

The input clamp is enabled only while the dummy-clamp pulse and the reference-sample pulse are both active. This coincidence rule also covers systems that have no separate dummy pulse and drive the dummy input with the black-clamp timing. The black-level loop is enabled by the black-clamp pulse. Pre-blanking suppresses that enable, and an overlap flag reports a black clamp that was requested while blanking was active. A standby bit masks everything: all strobes go inactive and the conversion clock output is parked high.

All outputs are combinational from the inputs and the configuration register. No latency is added, so pulse edges keep their relative timing. The configuration register changes only through its write port.

Top module: `smp_clp_cond`

## Requirements
- R1: After reset every polarity bit is 0 (active low) and standby is off. With all raw pulses low, the reference, data, input-clamp and black-loop strobes are high and the overlap flag is low.
- R2: Each strobe equals its raw input XNOR its polarity bit. Polarity 1 means active high and polarity 0 means active low. The bit positions are: config bit 0 for reference sample, bit 1 for data sample, bit 2 for dummy clamp and bit 3 for black clamp. Each bit acts only on its own channel.
- R3: `in_clp_o` is high exactly when the normalized dummy-clamp and reference-sample pulses are both active.
- R4: `blk_loop_o` is high exactly when the normalized black-clamp pulse is active and `preblank_i` is low.
- R5: `ovl_o` is high exactly when the normalized black-clamp pulse is active and `preblank_i` is high.
- R6: While the standby bit (config bit 4) is 1, every strobe and `ovl_o` is 0 and `cnv_clk_o` is 1, whatever the inputs are.
- R7: While standby is 0, `cnv_clk_o` equals `cnv_clk_i` in the same cycle.
- R8: `cfg_data_i` is loaded at a rising clock edge at which `cfg_wr_i` is 1, and takes effect right after that edge. With `cfg_wr_i` at 0 the configuration holds, and the outputs keep following the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 5 | Bits 3:0 polarity (ref, data, dummy, black); bit 4 standby |
| ref_smp_i | input | 1 | Raw reference-sample pulse |
| dat_smp_i | input | 1 | Raw data-sample pulse |
| dmy_clp_i | input | 1 | Raw dummy-pixel clamp pulse |
| blk_clp_i | input | 1 | Raw black-pixel clamp pulse |
| preblank_i | input | 1 | Pre-blanking active, high true |
| cnv_clk_i | input | 1 | Conversion clock in |
| cnv_clk_o | output | 1 | Conversion clock out, held high in standby |
| ref_smp_o | output | 1 | Active-high reference-sample strobe |
| dat_smp_o | output | 1 | Active-high data-sample strobe |
| in_clp_o | output | 1 | Input-clamp enable |
| blk_loop_o | output | 1 | Black-level loop enable |
| ovl_o | output | 1 | Black clamp requested during pre-blanking |

## Verification
The black-clamp pulse and pre-blanking can fall in the same cycle. In that cycle the loop enable must drop while the overlap flag rises. Separately, the dummy-clamp and reference-sample pulses must coincide before the input clamp fires. The bench steps through all 64 combinations of the four raw pulses, pre-blanking and the conversion clock under each of the 32 configurations, so every coincidence and overlap is hit with both polarities. Each output is compared against a value computed from the XNOR and AND rules, and standby is checked to override all of them.

// File: rtl/smp_clp_pkg.sv
package smp_clp_pkg;
    localparam int NCH    = 4;
    localparam int CH_REF = 0;
    localparam int CH_DAT = 1;
    localparam int CH_DMY = 2;
    localparam int CH_BLK = 3;
    localparam int CFGW   = NCH + 1;

    typedef struct packed {
        logic           stby;
        logic [NCH-1:0] pol;
    } cfg_t;

    localparam cfg_t CFG_RST = '{stby: 1'b0, pol: '0};
endpackage

// File: rtl/smp_clp_cfg.sv
module smp_clp_cfg
    import smp_clp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [CFGW-1:0] wdata_i,
    output cfg_t            cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d = cfg_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/smp_clp_norm.sv
module smp_clp_norm #(
    parameter int N = 4
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] pol_i,
    input  logic         mask_i,
    output logic [N-1:0] act_o
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        always_comb begin
            act_o[g] = !mask_i && (raw_i[g] ~^ pol_i[g]);
        end
    end
endmodule

// File: rtl/smp_clp_cond.sv
module smp_clp_cond
    import smp_clp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr_i,
    input  logic [CFGW-1:0] cfg_data_i,
    input  logic            ref_smp_i,
    input  logic            dat_smp_i,
    input  logic            dmy_clp_i,
    input  logic            blk_clp_i,
    input  logic            preblank_i,
    input  logic            cnv_clk_i,
    output logic            cnv_clk_o,
    output logic            ref_smp_o,
    output logic            dat_smp_o,
    output logic            in_clp_o,
    output logic            blk_loop_o,
    output logic            ovl_o
);
    cfg_t           cfg_q;
    logic [NCH-1:0] raw;
    logic [NCH-1:0] act;

    smp_clp_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_data_i),
        .cfg_o   (cfg_q)
    );

    always_comb begin
        raw         = '0;
        raw[CH_REF] = ref_smp_i;
        raw[CH_DAT] = dat_smp_i;
        raw[CH_DMY] = dmy_clp_i;
        raw[CH_BLK] = blk_clp_i;
    end

    smp_clp_norm #(.N(NCH)) i_norm (
        .raw_i  (raw),
        .pol_i  (cfg_q.pol),
        .mask_i (cfg_q.stby),
        .act_o  (act)
    );

    always_comb begin
        cnv_clk_o  = cfg_q.stby ? 1'b1 : cnv_clk_i;
        ref_smp_o  = act[CH_REF];
        dat_smp_o  = act[CH_DAT];
        in_clp_o   = act[CH_DMY] && act[CH_REF];
        blk_loop_o = act[CH_BLK] && !preblank_i;
        ovl_o      = act[CH_BLK] && preblank_i;
    end
endmodule

// File: rtl/smp_clp_cond_chk.sv
module smp_clp_cond_chk
    import smp_clp_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic cfg_wr_i,
    input cfg_t cfg_q,
    input logic preblank_i,
    input logic cnv_clk_i,
    input logic cnv_clk_o,
    input logic ref_smp_o,
    input logic dat_smp_o,
    input logic in_clp_o,
    input logic blk_loop_o,
    input logic ovl_o
);
    AST_STBY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.stby |-> (!ref_smp_o && !dat_smp_o && !in_clp_o && !blk_loop_o && !ovl_o && cnv_clk_o)); // R6

    AST_CLAMP_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        in_clp_o |-> ref_smp_o); // R3

    AST_LOOP_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        preblank_i |-> !blk_loop_o); // R4

    AST_OVL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_o |-> (preblank_i && !blk_loop_o)); // R5

    AST_CLK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.stby |-> (cnv_clk_o == cnv_clk_i)); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(cfg_q)); // R8
endmodule

bind smp_clp_cond smp_clp_cond_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_q      (cfg_q),
    .preblank_i (preblank_i),
    .cnv_clk_i  (cnv_clk_i),
    .cnv_clk_o  (cnv_clk_o),
    .ref_smp_o  (ref_smp_o),
    .dat_smp_o  (dat_smp_o),
    .in_clp_o   (in_clp_o),
    .blk_loop_o (blk_loop_o),
    .ovl_o      (ovl_o)
);

// File: tb/test_smp_clp_cond.sv
`timescale 1ns/1ps
module test_smp_clp_cond;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [4:0] cfg_data_i = '0;
    logic       ref_smp_i = 1'b0, dat_smp_i = 1'b0, dmy_clp_i = 1'b0, blk_clp_i = 1'b0;
    logic       preblank_i = 1'b0, cnv_clk_i = 1'b0;
    logic       cnv_clk_o, ref_smp_o, dat_smp_o, in_clp_o, blk_loop_o, ovl_o;

    int n_run  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    smp_clp_cond i_smp_clp_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_data_i (cfg_data_i),
        .ref_smp_i  (ref_smp_i),
        .dat_smp_i  (dat_smp_i),
        .dmy_clp_i  (dmy_clp_i),
        .blk_clp_i  (blk_clp_i),
        .preblank_i (preblank_i),
        .cnv_clk_i  (cnv_clk_i),
        .cnv_clk_o  (cnv_clk_o),
        .ref_smp_o  (ref_smp_o),
        .dat_smp_o  (dat_smp_o),
        .in_clp_o   (in_clp_o),
        .blk_loop_o (blk_loop_o),
        .ovl_o      (ovl_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [4:0] v);
        @(negedge clk);
        cfg_wr_i   = 1'b1;
        cfg_data_i = v;
        @(negedge clk);
        cfg_wr_i   = 1'b0;
    endtask

    // Expected outputs from the requirements for config c and stimulus s
    // (s[3:0] raw ref,data,dummy,black; s[4] preblank; s[5] conversion clock)
    task automatic check_all(input logic [4:0] c, input logic [5:0] s, input string tag);
        logic [3:0] act;
        logic       sb;
        sb = c[4];
        for (int i = 0; i < 4; i++) act[i] = !sb && (s[i] == c[i]);
        if (sb) begin
            chk({"R6 stby ", tag}, ref_smp_o | dat_smp_o | in_clp_o | blk_loop_o | ovl_o, 1'b0);
            chk({"R6 clk ", tag}, cnv_clk_o, 1'b1);
        end else begin
            chk({"R2 ref ", tag}, ref_smp_o, act[0]);
            chk({"R2 dat ", tag}, dat_smp_o, act[1]);
            chk({"R3 inclp ", tag}, in_clp_o, act[2] & act[0]);
            chk({"R4 loop ", tag}, blk_loop_o, act[3] & !s[4]);
            chk({"R5 ovl ", tag}, ovl_o, act[3] & s[4]);
            chk({"R7 clk ", tag}, cnv_clk_o, s[5]);
        end
    endtask

    task automatic apply(input logic [5:0] s);
        ref_smp_i  = s[0];
        dat_smp_i  = s[1];
        dmy_clp_i  = s[2];
        blk_clp_i  = s[3];
        preblank_i = s[4];
        cnv_clk_i  = s[5];
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset defaults, all raw low with active-low polarity
        chk("R1 ref", ref_smp_o, 1'b1);
        chk("R1 dat", dat_smp_o, 1'b1);
        chk("R1 inclp", in_clp_o, 1'b1);
        chk("R1 loop", blk_loop_o, 1'b1);
        chk("R1 ovl", ovl_o, 1'b0);
        chk("R1 clk", cnv_clk_o, 1'b0);

        for (int c = 0; c < 32; c++) begin
            write_cfg(5'(c));
            for (int s = 0; s < 64; s++) begin
                apply(6'(s));
                #1;
                check_all(5'(c), 6'(s), "sweep");
            end
            // R8: data presented without write strobe must not change behaviour
            @(negedge clk);
            cfg_data_i = ~5'(c);
            apply(6'b010101);
            @(negedge clk);
            #1;
            check_all(5'(c), 6'b010101, "R8 hold");
            apply(6'b101010);
            #1;
            check_all(5'(c), 6'b101010, "R8 hold");
        end

        // R8: a write takes effect right after the loading edge
        write_cfg(5'b01111);
        apply(6'b001111);
        #1;
        chk("R8 new cfg ref", ref_smp_o, 1'b1);
        chk("R8 new cfg loop", blk_loop_o, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule